// File: doc/BRIEF.md
# Multi-Policy Cache Victim Selector

This block decides which way of a set-associative cache is to be evicted. It keeps per-set and per-way bookkeeping: valid bits, a recency order, an insertion order and saturating use counters. When the surrounding cache controller asks which way to replace in a given set, the block answers one cycle later. Tag storage, data arrays and hit detection stay in the controller. The controller only reports its hits as touch strobes and its line fills as fill strobes, each with a set index and a way.

The eviction rule is picked at run time by a policy select. The five rules are least-recently-used, pseudo-random, first-in-first-out, least-frequently-used and most-recently-used. Every access updates the bookkeeping for all five rules, whichever rule is selected. The select can therefore change between any two queries, and the new rule answers at once from an order that is already correct. Under every rule, an empty way in the queried set is always chosen before an occupied one.

Top module: `victim_picker`

## Requirements
- R1: `victimValid` is high in exactly the cycle after a cycle with `queryValid` high. `victimWay` then carries that query's answer and holds it until the next query.
- R2: A synchronous reset (`rst` high) marks every way invalid. While any way of the queried set is invalid, the victim is the lowest-numbered invalid way, under every policy code.
- R3: Policy code 0 (least recently used): the victim is the way of the set whose last touch or fill is the oldest.
- R4: Policy code 1 (random): the victim is `lfsr % WAYS`, where `lfsr` is a 16-bit register. It loads 16'hACE1 while `rst` is high and otherwise steps every cycle to `{lfsr[14:0], lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]}`. The value used is the one held in the query cycle.
- R5: Policy code 2 (first in, first out): the victim is the way whose latest fill is the oldest. Touches do not change this order.
- R6: Policy code 3 (least frequently used): a fill sets the way's count to 1, and a touch adds 1, saturating at 2^CNT_W-1. The victim is the lowest-numbered way with the smallest count.
- R7: Policy code 4 (most recently used): the victim is the way of the set that was touched or filled most recently.
- R8: Changing the policy code clears no bookkeeping. Every touch and fill updates the state used by all five policies.
- R9: When a fill and a touch are strobed in the same cycle, only the fill is applied and the touch is dropped.
- R10: Policy codes 5, 6 and 7 select least recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| touchValid | input | 1 | Hit strobe for an existing line |
| touchSet | input | $clog2(SETS) | Set of the hit |
| touchWay | input | $clog2(WAYS) | Way of the hit |
| fillValid | input | 1 | Line fill strobe |
| fillSet | input | $clog2(SETS) | Set being filled |
| fillWay | input | $clog2(WAYS) | Way being filled |
| policySel | input | 3 | Eviction rule code |
| queryValid | input | 1 | Victim request strobe |
| querySet | input | $clog2(SETS) | Set to pick a victim in |
| victimWay | output | $clog2(WAYS) | Registered victim way |
| victimValid | output | 1 | High the cycle after a query |

## Verification
The checker assumes that fills arrive only through the fill strobe. It keeps its own copy of the valid bits, and that copy would go stale if a way could become valid any other way. The checker also assumes that set indices stay below SETS. The stimulus draws set and way indices only inside the configured range, and it aims touches only at ways already filled, as a real hit would. The random phase mixes single touches, single fills and same-cycle fill-plus-touch pairs. After every operation it queries all five policies, so that switching policies and tie-breaking are exercised against a timestamp model in the bench.

// File: rtl/victim_pkg.sv
package victim_pkg;

  typedef enum logic [2:0] {
    POL_LRU  = 3'd0,
    POL_RAND = 3'd1,
    POL_FIFO = 3'd2,
    POL_LFU  = 3'd3,
    POL_MRU  = 3'd4
  } policy_e;

  typedef struct packed {
    logic    fillEn;
    logic    touchEn;
    logic    queryEn;
    policy_e policy;
  } ctrl_s;

endpackage

// File: rtl/victim_ctrl.sv
module victim_ctrl
  import victim_pkg::*;
(
  input  logic       touchValid,
  input  logic       fillValid,
  input  logic       queryValid,
  input  logic [2:0] policySel,
  output ctrl_s      ctrl
);

  policy_e policyDec;

  // Codes above the defined set fall back to least recently used.
  always_comb begin
    case (policySel)
      3'd1:    policyDec = POL_RAND;
      3'd2:    policyDec = POL_FIFO;
      3'd3:    policyDec = POL_LFU;
      3'd4:    policyDec = POL_MRU;
      default: policyDec = POL_LRU;
    endcase
  end

  // A fill wins over a touch strobed in the same cycle.
  always_comb begin
    ctrl.fillEn  = fillValid;
    ctrl.touchEn = touchValid & ~fillValid;
    ctrl.queryEn = queryValid;
    ctrl.policy  = policyDec;
  end

endmodule

// File: rtl/victim_lfsr.sv
module victim_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] rnd
);

  logic feedback;

  assign feedback = rnd[15] ^ rnd[13] ^ rnd[12] ^ rnd[10];

  always_ff @(posedge clk) begin
    if (rst) rnd <= SEED;
    else     rnd <= {rnd[14:0], feedback};
  end

endmodule

// File: rtl/victim_dp.sv
module victim_dp
  import victim_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 8,
  parameter int CNT_W = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_s            ctrl,
  input  logic [SET_W-1:0] touchSet,
  input  logic [WAY_W-1:0] touchWay,
  input  logic [SET_W-1:0] fillSet,
  input  logic [WAY_W-1:0] fillWay,
  input  logic [SET_W-1:0] querySet,
  input  logic [15:0]      rnd,
  output logic [WAY_W-1:0] victimWay,
  output logic             victimValid
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [WAY_W-1:0] RANK_OLD = WAY_W'(WAYS - 1);

  // Per-set state. Rank 0 is the newest entry, WAYS-1 the oldest.
  logic             validQ   [SETS][WAYS];
  logic [WAY_W-1:0] recRank  [SETS][WAYS];
  logic [WAY_W-1:0] fifoRank [SETS][WAYS];
  logic [CNT_W-1:0] useCnt   [SETS][WAYS];

  logic             updAny;
  logic [SET_W-1:0] updSet;
  logic [WAY_W-1:0] updWay;

  assign updAny = ctrl.fillEn | ctrl.touchEn;
  assign updSet = ctrl.fillEn ? fillSet : touchSet;
  assign updWay = ctrl.fillEn ? fillWay : touchWay;

  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        if (rst) begin
          validQ[s][w]   <= 1'b0;
          recRank[s][w]  <= WAY_W'(w);
          fifoRank[s][w] <= WAY_W'(w);
          useCnt[s][w]   <= '0;
        end else if (updAny && updSet == SET_W'(s)) begin
          // Recency order moves the accessed way to the front.
          if (updWay == WAY_W'(w))
            recRank[s][w] <= '0;
          else if (recRank[s][w] < recRank[s][updWay])
            recRank[s][w] <= recRank[s][w] + 1'b1;
          if (ctrl.fillEn) begin
            if (updWay == WAY_W'(w)) begin
              fifoRank[s][w] <= '0;
              validQ[s][w]   <= 1'b1;
              useCnt[s][w]   <= CNT_W'(1);
            end else if (fifoRank[s][w] < fifoRank[s][updWay]) begin
              fifoRank[s][w] <= fifoRank[s][w] + 1'b1;
            end
          end else if (updWay == WAY_W'(w) && useCnt[s][w] != CNT_MAX) begin
            useCnt[s][w] <= useCnt[s][w] + 1'b1;
          end
        end
      end
    end
  end

  // Rows of the queried set.
  logic             rowValid [WAYS];
  logic [WAY_W-1:0] rowRec   [WAYS];
  logic [WAY_W-1:0] rowFifo  [WAYS];
  logic [CNT_W-1:0] rowCnt   [WAYS];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rowValid[w] = validQ[querySet][w];
      rowRec[w]   = recRank[querySet][w];
      rowFifo[w]  = fifoRank[querySet][w];
      rowCnt[w]   = useCnt[querySet][w];
    end
  end

  logic [WAYS-1:0] invMask, lruMask, mruMask, fifoMask;

  for (genvar w = 0; w < WAYS; w++) begin : g_mask
    assign invMask[w]  = ~rowValid[w];
    assign lruMask[w]  = (rowRec[w] == RANK_OLD);
    assign mruMask[w]  = (rowRec[w] == '0);
    assign fifoMask[w] = (rowFifo[w] == RANK_OLD);
  end

  function automatic logic [WAY_W-1:0] lowestOf(input logic [WAYS-1:0] mask);
    logic [WAY_W-1:0] idx;
    idx = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (mask[w]) idx = WAY_W'(w);
    return idx;
  endfunction

  logic [WAY_W-1:0] lfuIdx;
  logic [CNT_W-1:0] lfuMin;

  always_comb begin
    lfuIdx = '0;
    lfuMin = rowCnt[0];
    for (int w = 1; w < WAYS; w++) begin
      if (rowCnt[w] < lfuMin) begin
        lfuMin = rowCnt[w];
        lfuIdx = WAY_W'(w);
      end
    end
  end

  logic [WAY_W-1:0] randIdx;
  logic [WAY_W-1:0] pick;

  assign randIdx = WAY_W'(rnd % 16'(WAYS));

  always_comb begin
    if (|invMask) begin
      pick = lowestOf(invMask);
    end else begin
      case (ctrl.policy)
        POL_RAND: pick = randIdx;
        POL_FIFO: pick = lowestOf(fifoMask);
        POL_LFU:  pick = lfuIdx;
        POL_MRU:  pick = lowestOf(mruMask);
        default:  pick = lowestOf(lruMask);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      victimValid <= 1'b0;
      victimWay   <= '0;
    end else begin
      victimValid <= ctrl.queryEn;
      if (ctrl.queryEn) victimWay <= pick;
    end
  end

endmodule

// File: rtl/victim_picker.sv
module victim_picker
  import victim_pkg::*;
#(
  parameter int          WAYS  = 4,
  parameter int          SETS  = 8,
  parameter int          CNT_W = 4,
  parameter logic [15:0] SEED  = 16'hACE1,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touchValid,
  input  logic [SET_W-1:0] touchSet,
  input  logic [WAY_W-1:0] touchWay,
  input  logic             fillValid,
  input  logic [SET_W-1:0] fillSet,
  input  logic [WAY_W-1:0] fillWay,
  input  logic [2:0]       policySel,
  input  logic             queryValid,
  input  logic [SET_W-1:0] querySet,
  output logic [WAY_W-1:0] victimWay,
  output logic             victimValid
);

  ctrl_s       ctrl;
  logic [15:0] rnd;

  victim_ctrl u_ctrl (
    .touchValid (touchValid),
    .fillValid  (fillValid),
    .queryValid (queryValid),
    .policySel  (policySel),
    .ctrl       (ctrl)
  );

  victim_lfsr #(.SEED(SEED)) u_lfsr (
    .clk (clk),
    .rst (rst),
    .rnd (rnd)
  );

  victim_dp #(.WAYS(WAYS), .SETS(SETS), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrl),
    .touchSet    (touchSet),
    .touchWay    (touchWay),
    .fillSet     (fillSet),
    .fillWay     (fillWay),
    .querySet    (querySet),
    .rnd         (rnd),
    .victimWay   (victimWay),
    .victimValid (victimValid)
  );

endmodule

// File: rtl/victim_checker.sv
module victim_checker #(
  parameter int WAYS = 4,
  parameter int SETS = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst,
  input logic             fillValid,
  input logic [SET_W-1:0] fillSet,
  input logic [WAY_W-1:0] fillWay,
  input logic             queryValid,
  input logic [SET_W-1:0] querySet,
  input logic [WAY_W-1:0] victimWay,
  input logic             victimValid
);

  logic [WAYS-1:0] shadow [SETS];

  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      if (rst) shadow[s] <= '0;
      else if (fillValid && fillSet == SET_W'(s)) shadow[s][fillWay] <= 1'b1;
    end
  end

  logic             hasInv;
  logic [WAY_W-1:0] lowInv;

  always_comb begin
    hasInv = 1'b0;
    lowInv = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!shadow[querySet][w]) begin
        hasInv = 1'b1;
        lowInv = WAY_W'(w);
      end
    end
  end

  // R1: answer flagged exactly one cycle after a query
  a_r1_valid_next: assert property (@(posedge clk) disable iff (rst)
    queryValid |=> victimValid);

  // R1: no answer flagged without a query
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !queryValid |=> !victimValid);

  // R1: answer holds between queries
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !queryValid |=> $stable(victimWay));

  // R2: an empty way always wins
  a_r2_invalid_first: assert property (@(posedge clk) disable iff (rst)
    (queryValid && hasInv) |=> (victimWay == $past(lowInv)));

endmodule

bind victim_picker victim_checker #(.WAYS(WAYS), .SETS(SETS)) u_chk (.*);

// File: tb/victim_picker_bench.sv
`timescale 1ns/1ps
module victim_picker_bench;

  localparam int WAYS = 4;
  localparam int SETS = 8;
  localparam int CMAX = 15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       touchValid = 1'b0, fillValid = 1'b0, queryValid = 1'b0;
  logic [2:0] touchSet = '0, fillSet = '0, querySet = '0;
  logic [1:0] touchWay = '0, fillWay = '0;
  logic [2:0] policySel = '0;
  logic [1:0] victimWay;
  logic       victimValid;

  always #2.5 clk = ~clk;

  victim_picker u_victim_picker (
    .clk(clk), .rst(rst),
    .touchValid(touchValid), .touchSet(touchSet), .touchWay(touchWay),
    .fillValid(fillValid), .fillSet(fillSet), .fillWay(fillWay),
    .policySel(policySel), .queryValid(queryValid), .querySet(querySet),
    .victimWay(victimWay), .victimValid(victimValid)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Pseudo-random sequence from the R4 definition.
  logic [15:0] lfsrM;
  always @(posedge clk) begin
    if (rst) lfsrM <= 16'hACE1;
    else     lfsrM <= {lfsrM[14:0], lfsrM[15] ^ lfsrM[13] ^ lfsrM[12] ^ lfsrM[10]};
  end

  // Timestamp model.
  bit mValid [SETS][WAYS];
  int mLast  [SETS][WAYS];
  int mFill  [SETS][WAYS];
  int mCnt   [SETS][WAYS];
  int tick = 1;

  function automatic int expVictim(int s, int pol, logic [15:0] l);
    int best;
    for (int w = 0; w < WAYS; w++) if (!mValid[s][w]) return w;
    best = 0;
    case (pol)
      1: return int'(l % 16'(WAYS));
      2: begin
        for (int w = 1; w < WAYS; w++) if (mFill[s][w] < mFill[s][best]) best = w;
      end
      3: begin
        for (int w = 1; w < WAYS; w++) if (mCnt[s][w] < mCnt[s][best]) best = w;
      end
      4: begin
        for (int w = 1; w < WAYS; w++) if (mLast[s][w] > mLast[s][best]) best = w;
      end
      default: begin
        for (int w = 1; w < WAYS; w++) if (mLast[s][w] < mLast[s][best]) best = w;
      end
    endcase
    return best;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doOp(input bit f, input int fs, input int fw,
                      input bit t, input int ts, input int tw);
    @(negedge clk);
    fillValid = f;  fillSet = 3'(fs);  fillWay = 2'(fw);
    touchValid = t; touchSet = 3'(ts); touchWay = 2'(tw);
    @(negedge clk);
    fillValid = 0; touchValid = 0;
    if (f) begin
      mValid[fs][fw] = 1; mLast[fs][fw] = tick; mFill[fs][fw] = tick; mCnt[fs][fw] = 1;
    end else if (t) begin
      mLast[ts][tw] = tick;
      if (mCnt[ts][tw] < CMAX) mCnt[ts][tw]++;
    end
    tick++;
  endtask

  task automatic fill(input int s, input int w);
    doOp(1, s, w, 0, 0, 0);
  endtask

  task automatic touch(input int s, input int w);
    doOp(0, 0, 0, 1, s, w);
  endtask

  task automatic query(input int s, input int pol, input string tag);
    int exp;
    @(negedge clk);
    queryValid = 1; querySet = 3'(s); policySel = 3'(pol);
    exp = expVictim(s, pol, lfsrM);
    @(negedge clk);
    queryValid = 0;
    check(victimValid === 1'b1, {tag, " valid"}, int'(victimValid), 1);
    check(int'(victimWay) == exp, tag, int'(victimWay), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int st;
    int held;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mValid[s][w] = 0; mLast[s][w] = 0; mFill[s][w] = 0; mCnt[s][w] = 0;
      end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(victimValid === 1'b0, "R1 reset valid", int'(victimValid), 0);
    check(victimWay === 2'd0, "R1 reset way", int'(victimWay), 0);

    // R2: empty ways first, every policy
    for (int p = 0; p < 8; p++) query(0, p, "R2 empty set");
    fill(0, 0); fill(0, 2);
    for (int p = 0; p < 5; p++) query(0, p, "R2 lowest invalid");
    fill(0, 1);
    query(0, 3, "R2 last invalid");

    // R1: hold between queries
    held = int'(victimWay);
    repeat (3) @(negedge clk);
    check(victimValid === 1'b0, "R1 idle valid", int'(victimValid), 0);
    check(int'(victimWay) == held, "R1 hold", int'(victimWay), held);

    // R3 R5 R7: orders after fills and a touch
    fill(1, 3); fill(1, 1); fill(1, 0); fill(1, 2);
    touch(1, 3);
    query(1, 0, "R3 lru");
    query(1, 2, "R5 fifo ignores touch");
    query(1, 4, "R7 mru");
    check(int'(victimWay) == 3, "R7 mru direct", int'(victimWay), 3);
    // R10: unused codes act as LRU
    query(1, 5, "R10 code5");
    query(1, 6, "R10 code6");
    query(1, 7, "R10 code7");
    check(int'(victimWay) == 1, "R10 direct", int'(victimWay), 1);

    // R6: saturation and minimum count
    for (int w = 0; w < WAYS; w++) fill(2, w);
    repeat (20) touch(2, 0);
    repeat (9)  touch(2, 1);
    repeat (12) touch(2, 2);
    repeat (13) touch(2, 3);
    query(2, 3, "R6 lfu saturate");
    check(int'(victimWay) == 1, "R6 direct", int'(victimWay), 1);
    fill(2, 3);
    query(2, 3, "R6 fill resets count");

    // R9: fill beats a same-cycle touch
    for (int w = 0; w < WAYS; w++) fill(3, w);
    doOp(1, 3, 0, 1, 3, 1);
    query(3, 0, "R9 touch dropped");
    check(int'(victimWay) == 1, "R9 direct", int'(victimWay), 1);

    // R4: random selection
    for (int w = 0; w < WAYS; w++) fill(4, w);
    for (int i = 0; i < 12; i++) begin
      query(4, 1, "R4 random");
      repeat (i % 3) @(negedge clk);
    end

    // R8: mixed traffic, all policies queried after each operation
    st = 32'h1234567;
    for (int i = 0; i < 300; i++) begin
      int s, w, k;
      st = st * 1103515245 + 12345;
      s = (st >>> 8) & 7;
      w = (st >>> 12) & 3;
      k = (st >>> 16) & 7;
      if (k < 3 || !mValid[s][w]) begin
        if (k == 0) doOp(1, s, w, 1, s, (w + 1) % WAYS);
        else        fill(s, w);
      end else begin
        touch(s, w);
      end
      for (int p = 0; p < 5; p++) query(s, p, "R8 mixed");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule